// File: doc/BRIEF.md
# Sixteen-Bit Flag-Driven Arithmetic Logic Unit

This block is a purely combinational two-operand datapath unit for 16-bit words. A six-bit function code selects the operation. Its top two bits pick one of four operation families: arithmetic, bitwise logic, shifting and signed comparison. The bottom four bits pick the operation within that family. The block returns a 16-bit result word and three status flags (zero, negative, overflow).

The status flags always describe the shared adder. The adder subtracts for the subtract code and for every comparison code. For all other codes it adds. Comparisons have no magnitude comparator of their own. Each verdict is worked out from the adder's flags while it forms A minus B, and it is returned as a single bit in the least significant position of the result.

The unit is meant to sit between operand registers and a result register in a larger pipeline. No state lives inside it, so its outputs follow its inputs within the same cycle.

Top module: `alu16_core`

## Requirements
- R1: The family is chosen by fn_i[5:4]: 00 arithmetic, 01 logic, 10 shift, 11 compare. Any function code not named in R2 to R9 yields a result of 0x0000.
- R2: Arithmetic code 0000 returns (A + B) modulo 2^16.
- R3: Arithmetic code 0001 returns (A - B) modulo 2^16.
- R4: Arithmetic code 0010 returns the low 16 bits of the product A × B.
- R5: Logic codes: 1000 AND, 0111 NAND, 1110 OR, 0001 NOR, 0110 XOR, 1010 returns A unchanged, 0101 returns B unchanged.
- R6: Shift codes 0000 (logical left) and 0001 (logical right) move A by the amount in B[3:0]. Vacated positions are filled with zeros, and B[15:4] is ignored.
- R7: Shift code 0011 moves A right by B[3:0] and fills vacated positions with copies of A[15].
- R8: Compare code 0011 puts 1 in result bit 0 exactly when A equals B.
- R9: Compare code 0101 puts 1 in bit 0 when A < B as signed numbers. Compare code 0111 does the same when A ≤ B as signed numbers. Both hold even when A minus B overflows.
- R10: zero_o is 1 exactly when the adder's 16-bit output is all zeros.
- R11: neg_o equals bit 15 of the adder's output.
- R12: ovf_o is 1 when the adder's signed result falls outside -32768..32767. The adder subtracts for arithmetic code 0001 and for every compare-family code, and adds for all other codes.
- R13: For every compare-family code, result bits 15:1 are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand; also the value that is shifted |
| b_i | input | 16 | Second operand; bits 3:0 give the shift distance |
| fn_i | input | 6 | Function code: family in bits 5:4, operation in bits 3:0 |
| result_o | output | 16 | Selected operation's result |
| zero_o | output | 1 | Adder output is zero |
| neg_o | output | 1 | Adder output bit 15 |
| ovf_o | output | 1 | Adder signed overflow |

## Verification
Every result and every flag is due in the same cycle as the stimulus, because no register lies between the inputs and the outputs. The bench applies new operands and a new code just after one rising edge. It then compares all four outputs against its behavioural model at the following falling edge, half a period later, when every path has settled. Each operand pair is applied under all 64 function codes, so the unlisted codes and the flags during non-arithmetic operations are covered along with the named operations.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [1:0] {
        FAM_ARITH = 2'b00,
        FAM_BOOL  = 2'b01,
        FAM_SHIFT = 2'b10,
        FAM_CMP   = 2'b11
    } family_e;

    localparam logic [3:0] OP_ADD   = 4'b0000;
    localparam logic [3:0] OP_SUB   = 4'b0001;
    localparam logic [3:0] OP_MUL   = 4'b0010;

    localparam logic [3:0] OP_AND   = 4'b1000;
    localparam logic [3:0] OP_NAND  = 4'b0111;
    localparam logic [3:0] OP_OR    = 4'b1110;
    localparam logic [3:0] OP_NOR   = 4'b0001;
    localparam logic [3:0] OP_XOR   = 4'b0110;
    localparam logic [3:0] OP_PASSA = 4'b1010;
    localparam logic [3:0] OP_PASSB = 4'b0101;

    localparam logic [3:0] OP_SLL   = 4'b0000;
    localparam logic [3:0] OP_SRL   = 4'b0001;
    localparam logic [3:0] OP_SRA   = 4'b0011;

    localparam logic [3:0] OP_EQ    = 4'b0011;
    localparam logic [3:0] OP_LT    = 4'b0101;
    localparam logic [3:0] OP_LE    = 4'b0111;

    typedef struct packed {
        logic zero;
        logic neg;
        logic ovf;
    } flags_t;

endpackage

// File: rtl/alu16_arith.sv
module alu16_arith
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic [W-1:0] prod_o,
    output flags_t       flags_o
);
    localparam int PW = 2 * W;

    logic [W-1:0]  b_eff_d;
    logic [W-1:0]  sum_d;
    logic [PW-1:0] prod_full_d;
    flags_t        flags_d;

    always_comb begin
        b_eff_d     = sub_i ? ~b_i : b_i;
        sum_d       = a_i + b_eff_d + {{(W-1){1'b0}}, sub_i};
        prod_full_d = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
        flags_d.zero = (sum_d == '0);
        flags_d.neg  = sum_d[W-1];
        flags_d.ovf  = ( a_i[W-1] &  b_eff_d[W-1] & ~sum_d[W-1])
                     | (~a_i[W-1] & ~b_eff_d[W-1] &  sum_d[W-1]);
    end

    assign sum_o   = sum_d;
    assign prod_o  = prod_full_d[W-1:0];
    assign flags_o = flags_d;

    always_comb begin
        if (flags_d.ovf) begin
            AST_OVF_SIGN_FLIP: assert (sum_d[W-1] != a_i[W-1])
                else $error("overflow without sign change"); // R12
        end
        if (!sub_i && (a_i[W-1] != b_i[W-1])) begin
            AST_NO_OVF_MIXED_ADD: assert (!flags_d.ovf)
                else $error("mixed-sign add overflowed"); // R12
        end
    end

endmodule

// File: rtl/alu16_bool.sv
module alu16_bool
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   op_i,
    output logic [W-1:0] res_o
);
    logic [W-1:0] res_d;

    always_comb begin
        case (op_i)
            OP_AND:   res_d = a_i & b_i;
            OP_NAND:  res_d = ~(a_i & b_i);
            OP_OR:    res_d = a_i | b_i;
            OP_NOR:   res_d = ~(a_i | b_i);
            OP_XOR:   res_d = a_i ^ b_i;
            OP_PASSA: res_d = a_i;
            OP_PASSB: res_d = b_i;
            default:  res_d = '0;
        endcase
    end

    assign res_o = res_d;

    always_comb begin
        if (op_i == OP_AND) begin
            AST_AND_SUBSET: assert ((res_d & ~a_i) == '0)
                else $error("AND set a bit absent from A"); // R5
        end
        if (op_i == OP_OR) begin
            AST_OR_SUPERSET: assert ((a_i & ~res_d) == '0)
                else $error("OR dropped a bit of A"); // R5
        end
    end

endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   op_i,
    output logic [W-1:0] res_o
);
    localparam int SHW = $clog2(W);

    logic [SHW-1:0] amt_d;
    logic [W-1:0]   res_d;

    always_comb begin
        amt_d = b_i[SHW-1:0];
        case (op_i)
            OP_SLL:  res_d = a_i << amt_d;
            OP_SRL:  res_d = a_i >> amt_d;
            OP_SRA:  res_d = W'($signed(a_i) >>> amt_d);
            default: res_d = '0;
        endcase
    end

    assign res_o = res_d;

    always_comb begin
        if (op_i == OP_SRL && amt_d != '0) begin
            AST_SRL_ZERO_FILL: assert (res_d[W-1] == 1'b0)
                else $error("logical right shift filled a one"); // R6
        end
        if (op_i == OP_SRA) begin
            AST_SRA_SIGN_KEEP: assert (res_d[W-1] == a_i[W-1])
                else $error("arithmetic right shift lost the sign"); // R7
        end
    end

endmodule

// File: rtl/alu16_cmp.sv
module alu16_cmp
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  flags_t       flags_i,
    input  logic [3:0]   op_i,
    output logic [W-1:0] res_o
);
    logic less_d;
    logic verdict_d;

    always_comb begin
        less_d = flags_i.neg ^ flags_i.ovf;
        case (op_i)
            OP_EQ:   verdict_d = flags_i.zero;
            OP_LT:   verdict_d = less_d;
            OP_LE:   verdict_d = flags_i.zero | less_d;
            default: verdict_d = 1'b0;
        endcase
        res_o = {{(W-1){1'b0}}, verdict_d};
    end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [5:0]   fn_i,
    output logic [W-1:0] result_o,
    output logic         zero_o,
    output logic         neg_o,
    output logic         ovf_o
);
    family_e      fam_d;
    logic [3:0]   op_d;
    logic         sub_d;
    logic [W-1:0] sum_w;
    logic [W-1:0] prod_w;
    logic [W-1:0] bool_w;
    logic [W-1:0] shift_w;
    logic [W-1:0] cmp_w;
    flags_t       flags_w;
    logic [W-1:0] result_d;

    always_comb begin
        fam_d = family_e'(fn_i[5:4]);
        op_d  = fn_i[3:0];
        sub_d = (fam_d == FAM_CMP) || (fam_d == FAM_ARITH && op_d == OP_SUB);
    end

    alu16_arith #(.W(W)) u_arith (
        .a_i     (a_i),
        .b_i     (b_i),
        .sub_i   (sub_d),
        .sum_o   (sum_w),
        .prod_o  (prod_w),
        .flags_o (flags_w)
    );

    alu16_bool #(.W(W)) u_bool (
        .a_i   (a_i),
        .b_i   (b_i),
        .op_i  (op_d),
        .res_o (bool_w)
    );

    alu16_shift #(.W(W)) u_shift (
        .a_i   (a_i),
        .b_i   (b_i),
        .op_i  (op_d),
        .res_o (shift_w)
    );

    alu16_cmp #(.W(W)) u_cmp (
        .flags_i (flags_w),
        .op_i    (op_d),
        .res_o   (cmp_w)
    );

    always_comb begin
        result_d = '0;
        case (fam_d)
            FAM_ARITH: begin
                if (op_d == OP_ADD || op_d == OP_SUB) result_d = sum_w;
                else if (op_d == OP_MUL)              result_d = prod_w;
            end
            FAM_BOOL:  result_d = bool_w;
            FAM_SHIFT: result_d = shift_w;
            FAM_CMP:   result_d = cmp_w;
            default:   result_d = '0;
        endcase
    end

    assign result_o = result_d;
    assign zero_o   = flags_w.zero;
    assign neg_o    = flags_w.neg;
    assign ovf_o    = flags_w.ovf;

    always_comb begin
        if (fam_d == FAM_CMP) begin
            AST_CMP_UPPER_CLEAR: assert (result_d[W-1:1] == '0)
                else $error("compare result has upper bits set"); // R13
            AST_CMP_ZERO_MEANS_EQ: assert (zero_o == (a_i == b_i))
                else $error("zero flag disagrees with operand equality"); // R10
        end
        if (fam_d == FAM_CMP && op_d == OP_EQ) begin
            AST_CMP_EQ_MATCH: assert (result_d[0] == (a_i == b_i))
                else $error("equality verdict wrong"); // R8
        end
        if (fam_d == FAM_CMP && op_d == OP_LT) begin
            AST_CMP_LT_SIGNED: assert (result_d[0] == ($signed(a_i) < $signed(b_i)))
                else $error("signed less-than verdict wrong"); // R9
        end
        if (fam_d == FAM_CMP && op_d == OP_LE) begin
            AST_CMP_LE_SIGNED: assert (result_d[0] == ($signed(a_i) <= $signed(b_i)))
                else $error("signed less-or-equal verdict wrong"); // R9
        end
    end

endmodule

// File: tb/test_alu16_core.sv
module test_alu16_core;
    localparam int CLK_PERIOD = 10;
    localparam int NPAIRS     = 50;

    logic        clk = 1'b0;
    logic [15:0] a, b;
    logic [5:0]  fn;
    logic [15:0] result;
    logic        zf, nf, vf;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alu16_core i_alu16_core (
        .a_i      (a),
        .b_i      (b),
        .fn_i     (fn),
        .result_o (result),
        .zero_o   (zf),
        .neg_o    (nf),
        .ovf_o    (vf)
    );

    function automatic string res_tag(input logic [5:0] f);
        case (f[5:4])
            2'b00: case (f[3:0])
                4'b0000: return "R2";
                4'b0001: return "R3";
                4'b0010: return "R4";
                default: return "R1";
            endcase
            2'b01: case (f[3:0])
                4'b1000, 4'b0111, 4'b1110, 4'b0001,
                4'b0110, 4'b1010, 4'b0101: return "R5";
                default: return "R1";
            endcase
            2'b10: case (f[3:0])
                4'b0000, 4'b0001: return "R6";
                4'b0011:          return "R7";
                default:          return "R1";
            endcase
            default: case (f[3:0])
                4'b0011:          return "R8";
                4'b0101, 4'b0111: return "R9";
                default:          return "R1";
            endcase
        endcase
    endfunction

    task automatic model(input logic [15:0] ma, input logic [15:0] mb,
                         input logic [5:0] mf, output logic [15:0] er,
                         output logic ez, output logic en, output logic ev);
        int sa, sb, exact, amt;
        logic sub;
        logic [15:0] s;
        logic [31:0] p;
        sa  = int'($signed(ma));
        sb  = int'($signed(mb));
        sub = (mf[5:4] == 2'b11) || (mf == 6'b000001);
        exact = sub ? sa - sb : sa + sb;
        s   = 16'(exact);
        ez  = (s == 16'h0);
        en  = s[15];
        ev  = (exact > 32767) || (exact < -32768);
        amt = int'(mb[3:0]);
        p   = 32'(ma) * 32'(mb);
        er  = 16'h0;
        case (mf)
            6'b000000: er = 16'(sa + sb);
            6'b000001: er = 16'(sa - sb);
            6'b000010: er = p[15:0];
            6'b011000: er = ma & mb;
            6'b010111: er = ~(ma & mb);
            6'b011110: er = ma | mb;
            6'b010001: er = ~(ma | mb);
            6'b010110: er = ma ^ mb;
            6'b011010: er = ma;
            6'b010101: er = mb;
            6'b100000: er = 16'(32'(ma) * (32'd1 << amt));
            6'b100001: er = 16'(32'(ma) / (32'd1 << amt));
            6'b100011: begin
                int q;
                q = sa;
                for (int k = 0; k < amt; k++) q = (q - ((q % 2 + 2) % 2)) / 2;
                er = 16'(q);
            end
            6'b110011: er = {15'h0, ma == mb};
            6'b110101: er = {15'h0, sa < sb};
            6'b110111: er = {15'h0, sa <= sb};
            default:   er = 16'h0;
        endcase
    endtask

    task automatic check(input string tag, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s a=%h b=%h fn=%b actual=%h expected=%h",
                     tag, what, a, b, fn, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] ta, input logic [15:0] tb,
                         input logic [5:0] tf);
        logic [15:0] er;
        logic ez, en, ev;
        @(posedge clk);
        #1;
        a = ta; b = tb; fn = tf;
        model(ta, tb, tf, er, ez, en, ev);
        @(negedge clk);
        check(res_tag(tf), "result", result, er);
        check("R10", "zero", {15'h0, zf}, {15'h0, ez});
        check("R11", "neg",  {15'h0, nf}, {15'h0, en});
        check("R12", "ovf",  {15'h0, vf}, {15'h0, ev});
        if (tf[5:4] == 2'b11)
            check("R13", "cmp-upper", {1'b0, result[15:1]}, 16'h0);
    endtask

    logic [15:0] pa [NPAIRS];
    logic [15:0] pb [NPAIRS];

    initial begin
        a = '0; b = '0; fn = '0;
        @(negedge clk);
        // idle state with all-zero inputs: add of zeros
        check("R2", "idle result", result, 16'h0);
        check("R10", "idle zero", {15'h0, zf}, 16'h1);

        pa[0] = 16'h0000; pb[0] = 16'h0000;
        pa[1] = 16'h7fff; pb[1] = 16'h0001;
        pa[2] = 16'h8000; pb[2] = 16'h0001;
        pa[3] = 16'h8000; pb[3] = 16'h8000;
        pa[4] = 16'hffff; pb[4] = 16'hffff;
        pa[5] = 16'h1234; pb[5] = 16'h5678;
        pa[6] = 16'h0005; pb[6] = 16'h0005;
        pa[7] = 16'h8000; pb[7] = 16'h7fff;
        pa[8] = 16'h7fff; pb[8] = 16'h8000;
        pa[9] = 16'ha5a5; pb[9] = 16'hfff7;
        pa[10] = 16'hc003; pb[10] = 16'h0f3f;
        pa[11] = 16'hfffe; pb[11] = 16'h0002;
        for (int i = 12; i < NPAIRS; i++) begin
            pa[i] = 16'($urandom);
            pb[i] = 16'($urandom);
        end

        for (int i = 0; i < NPAIRS; i++)
            for (int f = 0; f < 64; f++)
                apply(pa[i], pb[i], 6'(f));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule